// File: doc/BRIEF.md
# Normalized clock-enable generator

This block lets a multirate datapath run entirely on one fast system clock. Each rate domain in that datapath has a sample period that is an integer multiple of a common base period, which is the greatest common divisor of all rates. The base period is one clock cycle. For every configured multiple, the block raises an enable that lasts one cycle and repeats once per that many cycles. Logic in the slower domains uses these enables to decide when it advances. It never uses a derived clock.

A single shared counter counts cycles and wraps at the least common multiple of the configured periods. One comparator per domain tests whether the count is divisible by that domain's period, and the result is registered. Every enable fires on the first clock edge after reset is released, so all domains start in phase. From then on the enables stay periodic across every counter wrap.

Top module: `ce_gen`

## Requirements
- R1: While `rst_n` is low, every bit of `ce` is 0.
- R2: On the first rising clock edge sampled with `rst_n` high, every bit of `ce` becomes 1. This edge is cycle k = 0. The same applies after a reset that is asserted in the middle of a run.
- R3: An enable whose period is 1 stays high on every cycle from k = 0 onward.
- R4: Bit i of `ce`, which has period N = `PERIODS[i]`, is high in cycle k exactly when k mod N equals 0. Two consecutive pulses are therefore exactly N cycles apart.
- R5: For a period N greater than 1, each pulse lasts exactly one cycle: the cycle after a pulse is low.
- R6: The pattern in R4 holds without a break across the wrap of the internal counter, for any run length.
- R7: All enables are high together exactly in the cycles where k is a multiple of the least common multiple of all periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock, shared by all rate domains |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | output | NUM_RATES | One-cycle enable per configured period; bit i belongs to `PERIODS[i]` |

## Verification
The counter returns to zero in the same cycle that every enable fires together. That cycle is the most likely place for an off-by-one or a dropped pulse. The bench provokes it by running more than two full counter periods without stopping. In every cycle it compares each enable bit against k mod N, where k counts edges since reset release. It also counts the cycles in which all enables are high and checks that they fall exactly on multiples of the least common multiple. A second reset in the middle of a run, placed where the counter is not at zero, confirms that realignment restarts at k = 0.

// File: rtl/ce_gen.sv
module ce_gen #(
  parameter int NUM_RATES = 4,
  parameter int PERIODS [NUM_RATES] = '{1, 2, 3, 5}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic [NUM_RATES-1:0] ce
);

  function automatic int gcd_f(input int a_in, input int b_in);
    int a, b, t;
    a = a_in;
    b = b_in;
    while (b != 0) begin
      t = a % b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  function automatic int lcm_f();
    int l;
    l = 1;
    for (int i = 0; i < NUM_RATES; i++)
      l = (l / gcd_f(l, PERIODS[i])) * PERIODS[i];
    return l;
  endfunction

  localparam int LCM = lcm_f();
  localparam int CW  = (LCM > 1) ? $clog2(LCM) : 1;
  localparam logic [CW-1:0] LAST = CW'(LCM - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= wrap ? '0 : cnt + 1'b1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |-> ce == '0)
    else $error("p_reset_quiet_r1");

  p_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |=> &ce)
    else $error("p_align_r2");

  for (genvar i = 0; i < NUM_RATES; i++) begin : g_rate
    initial begin
      if (PERIODS[i] < 1) $error("period must be at least 1");
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ce[i] <= 1'b0;
      else        ce[i] <= (int'(cnt) % PERIODS[i]) == 0;
    end

    int gap;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        gap <= 0;
      else if (ce[i])    gap <= 1;
      else if (gap != 0) gap <= gap + 1;
    end

    p_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ce[i] && gap != 0) |-> gap == PERIODS[i])
      else $error("p_spacing_r4");

    p_no_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce[i] && gap != 0) |-> gap < PERIODS[i])
      else $error("p_no_drop_r6");

    if (PERIODS[i] == 1) begin : g_full
      p_every_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ce[i])
        else $error("p_every_cycle_r3");
    end else begin : g_pulse
      p_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ce[i] |=> !ce[i])
        else $error("p_single_r5");
    end
  end

endmodule

// File: tb/sim_ce_gen.sv
module sim_ce_gen;
  localparam int N = 4;
  localparam int P [N] = '{1, 2, 3, 5};
  localparam int L = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] ce;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ce_gen #(.NUM_RATES(N), .PERIODS(P)) u0 (.clk(clk), .rst_n(rst_n), .ce(ce));

  function automatic logic [N-1:0] expect_at(input int k);
    logic [N-1:0] e;
    for (int i = 0; i < N; i++) e[i] = (k % P[i]) == 0;
    return e;
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp, input int k);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s k=%0d actual=%b expected=%b", req, k, act, exp);
    end
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check("R1", ce, '0, -1);
    end
  endtask

  task automatic t_align_and_run(input int cycles);
    int coinc;
    release_reset();
    check("R2", ce, '1, 0);
    coinc = 0;
    for (int k = 0; k < cycles; k++) begin
      if (k > 0) begin
        @(posedge clk);
        @(negedge clk);
      end
      check("R4 R6", ce, expect_at(k), k);
      check("R3", ce[0], 1'b1, k);
      if (k > 0 && expect_at(k - 1)[1] == 1'b1) check("R5", ce[1], 1'b0, k);
      if (&ce) begin
        coinc++;
        check("R7", (k % L == 0), 1'b1, k);
      end
    end
    check("R7", coinc, (cycles + L - 1) / L, cycles);
  endtask

  task automatic t_midreset();
    release_reset();
    for (int k = 1; k < 17; k++) @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", ce, '0, -1);
    @(negedge clk);
    check("R1", ce, '0, -1);
    t_align_and_run(12);
  endtask

  initial begin
    t_reset();
    t_align_and_run(2 * L + 11);
    t_reset();
    t_midreset();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule